// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block cuts a run of `n` vector elements into strips that a vector unit can handle. Each strip holds at most `MVL` elements, where `MVL` is the machine's longest vector. The element count arrives at runtime and may be many times `MVL`. For every strip the sequencer supplies two values: the length to load into the vector-length register, and the index of the strip's first element.

The short piece comes first. Its length is `n mod MVL`. Every strip after it is a full `MVL` strip. If `n` is a whole multiple of `MVL`, there is no empty leading strip, and the sequence starts with a full one. Strips go out over a valid/ready handshake, one strip per acknowledgement. A strip stays fixed on the outputs until the consumer accepts it. After the last strip is taken, `done` rises and stays high until the next job starts. A job of zero elements goes straight to `done`.

`MVL` is a parameter. When it is a power of two, the remainder is the low bits of `n`. Otherwise a constant-divisor modulo is built.

Top module: `strip_seq`

## Requirements
- R1: After reset, `strip_valid` and `done` are both low.
- R2: Every offered strip length lies between 1 and MVL inclusive.
- R3: If n mod MVL is nonzero, the first strip of a job has length n mod MVL and start index 0.
- R4: If n is a nonzero multiple of MVL, the first strip has length MVL and start index 0.
- R5: Every strip after the first has length exactly MVL.
- R6: Each strip's start index equals the previous strip's start index plus the previous strip's length, and the lengths of a job sum to n.
- R7: While `strip_valid` is high and `strip_ready` is low, the strip's length and index stay unchanged and `strip_valid` stays high.
- R8: In the cycle after the last strip is accepted, `done` is high and `strip_valid` is low. `done` stays high until a new `start`.
- R9: A `start` with n equal to 0 raises `done` in the next cycle and offers no strip.
- R10: A `start` while a strip is being offered is ignored: the offered length and index do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job using `n_total`; taken only when no strip is offered |
| n_total | input | N_W | Element count of the job |
| strip_valid | output | 1 | A strip is offered |
| strip_ready | input | 1 | Consumer accepts the offered strip |
| strip_vl | output | VL_W | Length of the offered strip |
| strip_base | output | N_W | Index of the strip's first element |
| done | output | 1 | All strips of the job have been accepted |

## Verification
An accepted `start` at a clock edge puts the first strip on the outputs right after that edge, one cycle later. A zero-length job shows `done` one cycle after `start`. Each accepted handshake puts either the next strip or `done` on the outputs one cycle after the edge. The bench drives inputs on the falling edge and checks every result on the next falling edge, so each comparison lands half a cycle after the register that produced it. Stall cycles are checked on every falling edge while ready is held low.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_EMIT = 2'd1,
    SQ_FIN  = 2'd2
  } sq_state_t;

endpackage

// File: rtl/strip_rem.sv
// Remainder of the element count against the maximum vector length.
module strip_rem #(
  parameter int MVL  = 32,
  parameter int N_W  = 16,
  parameter int VL_W = $clog2(MVL + 1)
) (
  input  logic [N_W-1:0]  n_i,
  output logic [VL_W-1:0] rem_o
);

  localparam bit IS_POW2 = (MVL > 1) && ((MVL & (MVL - 1)) == 0);
  localparam logic [N_W-1:0] MVL_N  = N_W'(MVL);
  localparam logic [N_W-1:0] MASK_N = N_W'(MVL - 1);

  generate
    if (IS_POW2) begin : g_mask
      assign rem_o = VL_W'(n_i & MASK_N);
    end else begin : g_mod
      assign rem_o = VL_W'(n_i % MVL_N);
    end
  endgenerate

endmodule

// File: rtl/strip_fsm.sv
// Job control: idle, offering strips, finished.
module strip_fsm
  import strip_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic n_zero_i,
  input  logic fire_i,
  input  logic last_i,
  output logic load_o,
  output logic valid_o,
  output logic done_o
);

  sq_state_t state_q, state_d;
  logic      take;

  assign take   = start_i && (state_q != SQ_EMIT);
  assign load_o = take;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE, SQ_FIN: begin
        if (take) state_d = n_zero_i ? SQ_FIN : SQ_EMIT;
      end
      SQ_EMIT: begin
        if (fire_i && last_i) state_d = SQ_FIN;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign valid_o = (state_q == SQ_EMIT);
  assign done_o  = (state_q == SQ_FIN);

endmodule

// File: rtl/strip_dp.sv
// Strip length, start index and remaining count registers.
module strip_dp #(
  parameter int MVL  = 32,
  parameter int N_W  = 16,
  parameter int VL_W = $clog2(MVL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [N_W-1:0]  n_i,
  input  logic [VL_W-1:0] rem_i,
  output logic [VL_W-1:0] vl_o,
  output logic [N_W-1:0]  base_o,
  output logic            last_o
);

  localparam logic [VL_W-1:0] MVL_V = VL_W'(MVL);

  logic [VL_W-1:0] vl_q, vl_d;
  logic [N_W-1:0]  base_q, base_d;
  logic [N_W-1:0]  left_q, left_d;
  logic [N_W-1:0]  vl_ext;
  logic            en;

  assign vl_ext = {{(N_W - VL_W){1'b0}}, vl_q};
  assign en     = load_i || step_i;

  always_comb begin
    vl_d   = vl_q;
    base_d = base_q;
    left_d = left_q;
    if (load_i) begin
      vl_d   = (rem_i == '0) ? MVL_V : rem_i;
      base_d = '0;
      left_d = n_i;
    end else if (step_i) begin
      vl_d   = MVL_V;
      base_d = base_q + vl_ext;
      left_d = left_q - vl_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q   <= '0;
      base_q <= '0;
      left_q <= '0;
    end else if (en) begin
      vl_q   <= vl_d;
      base_q <= base_d;
      left_q <= left_d;
    end
  end

  assign vl_o   = vl_q;
  assign base_o = base_q;
  assign last_o = (left_q == vl_ext);

endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int MVL  = 32,
  parameter int N_W  = 16,
  parameter int VL_W = $clog2(MVL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N_W-1:0]  n_total,
  output logic            strip_valid,
  input  logic            strip_ready,
  output logic [VL_W-1:0] strip_vl,
  output logic [N_W-1:0]  strip_base,
  output logic            done
);

  logic [VL_W-1:0] rem;
  logic            load, last, fire, n_zero;

  assign n_zero = (n_total == '0);
  assign fire   = strip_valid && strip_ready;

  strip_rem #(.MVL(MVL), .N_W(N_W), .VL_W(VL_W)) u_rem (
    .n_i   (n_total),
    .rem_o (rem)
  );

  strip_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .n_zero_i (n_zero),
    .fire_i   (fire),
    .last_i   (last),
    .load_o   (load),
    .valid_o  (strip_valid),
    .done_o   (done)
  );

  strip_dp #(.MVL(MVL), .N_W(N_W), .VL_W(VL_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .step_i (fire),
    .n_i    (n_total),
    .rem_i  (rem),
    .vl_o   (strip_vl),
    .base_o (strip_base),
    .last_o (last)
  );

endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
  parameter int MVL  = 32,
  parameter int N_W  = 16,
  parameter int VL_W = $clog2(MVL + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [N_W-1:0]  n_total,
  input logic            strip_valid,
  input logic            strip_ready,
  input logic [VL_W-1:0] strip_vl,
  input logic [N_W-1:0]  strip_base,
  input logic            done
);

  AST_VL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    strip_valid |-> (strip_vl != '0) && (strip_vl <= VL_W'(MVL))); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (strip_valid && !strip_ready) |=> strip_valid && $stable(strip_vl) && $stable(strip_base)); // R7

  AST_LATER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (strip_valid && strip_ready) |=> (!strip_valid || strip_vl == VL_W'(MVL))); // R5

  AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strip_valid && strip_ready) |=>
      (!strip_valid || strip_base == $past(strip_base) + N_W'($past(strip_vl)))); // R6

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strip_valid && done)); // R8

  AST_ZERO_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !strip_valid && n_total == '0) |=> done && !strip_valid); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && strip_valid && !strip_ready) |=> $stable(strip_base) && $stable(strip_vl)); // R10

endmodule

bind strip_seq strip_seq_chk #(.MVL(MVL), .N_W(N_W), .VL_W(VL_W)) u_chk (.*);

// File: tb/test_strip_seq.sv
`timescale 1ns/1ps
module test_strip_seq;

  localparam int MVL  = 32;
  localparam int N_W  = 16;
  localparam int VL_W = $clog2(MVL + 1);

  logic            clk;
  logic            rst_n;
  logic            start;
  logic [N_W-1:0]  n_total;
  logic            strip_valid;
  logic            strip_ready;
  logic [VL_W-1:0] strip_vl;
  logic [N_W-1:0]  strip_base;
  logic            done;

  int checks;
  int fails;

  strip_seq #(.MVL(MVL), .N_W(N_W)) i_strip_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .n_total(n_total),
    .strip_valid(strip_valid), .strip_ready(strip_ready),
    .strip_vl(strip_vl), .strip_base(strip_base), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int first_len(input int n);
    return (n % MVL == 0) ? MVL : (n % MVL);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_job(input int n, input bit stalls);
    int base_e;
    int left;
    int len_e;
    int total;
    bit first;
    @(negedge clk);
    n_total = N_W'(n);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    if (n == 0) begin
      check(done && !strip_valid, "R9", {done, strip_valid}, 2);
      return;
    end
    base_e = 0; left = n; first = 1'b1; total = 0;
    while (left > 0) begin
      len_e = first ? first_len(n) : MVL;
      check(strip_valid == 1'b1, "R2", strip_valid, 1);
      if (first && (n % MVL != 0))
        check(int'(strip_vl) == len_e && strip_base == 0, "R3", strip_vl, len_e);
      else if (first)
        check(int'(strip_vl) == len_e && strip_base == 0, "R4", strip_vl, len_e);
      else
        check(int'(strip_vl) == MVL, "R5", strip_vl, MVL);
      check(int'(strip_base) == base_e, "R6", strip_base, base_e);
      if (stalls) begin
        for (int s = 0; s < int'($urandom % 3); s++) begin
          strip_ready = 1'b0;
          start   = ($urandom % 2) == 0;
          n_total = N_W'($urandom % 500);
          @(negedge clk);
          if (start) begin
            start = 1'b0;
            check(int'(strip_base) == base_e && int'(strip_vl) == len_e, "R10", strip_base, base_e);
          end
          check(strip_valid && int'(strip_vl) == len_e && int'(strip_base) == base_e,
                "R7", strip_vl, len_e);
        end
      end
      strip_ready = 1'b1;
      @(negedge clk);
      strip_ready = 1'b0;
      total  += len_e;
      base_e += len_e;
      left   -= len_e;
      first   = 1'b0;
    end
    check(total == n, "R6", total, n);
    check(done && !strip_valid, "R8", {done, strip_valid}, 2);
    @(negedge clk);
    check(done && !strip_valid, "R8", {done, strip_valid}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    checks = 0; fails = 0;
    seed = $urandom(32'h5eed_0007);
    rst_n = 1'b0; start = 1'b0; n_total = '0; strip_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!strip_valid && !done, "R1", {strip_valid, done}, 0);
    // directed corners
    run_job(0, 1'b0);
    run_job(1, 1'b0);
    run_job(MVL, 1'b0);
    run_job(MVL - 1, 1'b1);
    run_job(MVL + 1, 1'b1);
    run_job(3 * MVL, 1'b1);
    run_job(0, 1'b0);
    run_job(100, 1'b1);
    // constrained random jobs
    for (int j = 0; j < 40; j++) begin
      run_job(int'($urandom % 400), 1'b1);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule